// File: doc/BRIEF.md
# On-Board Memory and Port Select Decoder

This block sits beside a 16-bit processor on a board whose memory is byte-addressed but organised as 16-bit words. From the processor address and request strobes it works out which on-board device answers: a monitor ROM, an optional assembler ROM, or a single row of RAM. It also produces the two byte-lane enables for the word-wide memory and the selects for a small set of I/O ports.

Three strap inputs shape the board's behaviour. The first sets the role of a shared active-low inhibit line. That line can be left alone, driven to tell off-board memory to stand aside, or sampled so that off-board memory takes priority. The second strap asks for a single wait state on on-board memory cycles. The third input, a refresh qualifier, keeps both ROMs off the internal data bus while the RAM row is refreshed.

Top module: `board_mem_decode`

## Requirements
- R1: With `mem_req` high, `refresh` low and no blocking inhibit, exactly one select is high for on-board space: `sel_mon` for 0x0000–0x0FFF, `sel_asm` for 0x1000–0x2FFF, `sel_ram` for 0x4000–0x5FFF. No memory select is high for 0x3000–0x3FFF, for 0x6000–0xFFFF, or while `mem_req` is low.
- R2: A RAM read (`wr` low) drives `lane_en` to 2'b11, whether `byte_op` is high or low. `lane_en` is 2'b00 whenever no memory select is high. `lane_en[1]` is the high lane (data 15–8) and `lane_en[0]` is the low lane (data 7–0).
- R3: A RAM write with `byte_op` high enables one lane only: 2'b10 when `addr[0]` is 1 and 2'b01 when `addr[0]` is 0. A RAM word write enables 2'b11.
- R4: Any ROM access, read or write, byte or word, drives `lane_en` to 2'b11.
- R5: With `refresh` and `mem_req` high, both ROM selects are low and `sel_ram` is high at any address, with `lane_en` 2'b11, unless the inhibit input blocks.
- R6: With `inh_mode` = 2'b01 (drive), `inh_oe` is high and `inh_out_n` is low exactly when `mem_req` is high and the address is below 0x6000.
- R7: With `inh_mode` = 2'b10 (sample), `inh_oe` is low, and a low `inh_in_n` forces all memory selects and `lane_en` to zero.
- R8: With `inh_mode` = 2'b00 or 2'b11 (unused), `inh_oe` is low, `inh_out_n` is high, and `inh_in_n` has no effect on any select.
- R9: `wait_req` is high in the cycle after a clock edge at which `t2_end`, `wait_en` and some memory select were all high. Otherwise it is low, including after reset.
- R10: `io_sel[k]` is high only when `io_req` is high and `addr[11:2]` equals k. Address bits 15–12 and 1–0 do not matter. `mem_req` has no effect on `io_sel`, and an index at or above `IO_PORTS` selects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor byte address |
| mem_req | input | 1 | Memory request active |
| io_req | input | 1 | I/O request active |
| wr | input | 1 | Write (1) or read (0) |
| byte_op | input | 1 | Byte (1) or word (0) transfer |
| refresh | input | 1 | Current memory request is a refresh |
| t2_end | input | 1 | Marks the clock that closes phase T2 |
| wait_en | input | 1 | Strap: insert one wait state |
| inh_mode | input | 2 | Strap: inhibit role (00 none, 01 drive, 10 sample, 11 none) |
| inh_in_n | input | 1 | Sampled inhibit line, active low |
| sel_mon | output | 1 | Monitor ROM select |
| sel_asm | output | 1 | Assembler ROM select |
| sel_ram | output | 1 | RAM row select |
| lane_en | output | 2 | Byte lanes: [1] high, [0] low |
| inh_out_n | output | 1 | Inhibit drive value, active low |
| inh_oe | output | 1 | Inhibit line output enable |
| wait_req | output | 1 | Registered wait-state request |
| io_sel | output | 16 | One-hot I/O port selects |

## Verification
The bench probes each edge of the address map (0x0FFF/0x1000, 0x2FFF/0x3000, 0x3FFF/0x4000, 0x5FFF/0x6000). An off-by-one comparison there would light the wrong ROM, select RAM in the hole, or leave the inhibit output low one address too far. Byte writes at even and odd addresses catch swapped lanes and a RAM read that opens a single lane. Refresh at a ROM address catches a decoder that lets a ROM fight the RAM on the data bus. Random address, strap and strobe mixes cover the rest: a sampled inhibit honoured in the wrong mode, a wait request that ignores its strap or lasts too long, and port decode that looks at the upper nibble or the two low bits.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] MON_LO  = 16'h0000;
    localparam logic [ADDR_W-1:0] ASM_LO  = 16'h1000;
    localparam logic [ADDR_W-1:0] HOLE_LO = 16'h3000;
    localparam logic [ADDR_W-1:0] RAM_LO  = 16'h4000;
    localparam logic [ADDR_W-1:0] TOP_LO  = 16'h6000;

    typedef enum logic [2:0] {
        RGN_MON  = 3'd0,
        RGN_ASM  = 3'd1,
        RGN_HOLE = 3'd2,
        RGN_RAM  = 3'd3,
        RGN_OFF  = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        INH_NONE   = 2'b00,
        INH_DRIVE  = 2'b01,
        INH_SAMPLE = 2'b10,
        INH_SPARE  = 2'b11
    } inh_mode_e;

    typedef struct packed {
        logic mon;
        logic asm_rom;
        logic ram;
    } mem_sel_t;

    typedef struct packed {
        logic wr;
        logic byte_op;
        logic odd;
        logic refresh;
    } xfer_t;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        if (a < ASM_LO)       return RGN_MON;
        else if (a < HOLE_LO) return RGN_ASM;
        else if (a < RAM_LO)  return RGN_HOLE;
        else if (a < TOP_LO)  return RGN_RAM;
        else                  return RGN_OFF;
    endfunction

    function automatic logic in_board_space(input logic [ADDR_W-1:0] a);
        return a < TOP_LO;
    endfunction

    function automatic logic [1:0] ram_lanes(input xfer_t x);
        if (x.refresh || !x.wr || !x.byte_op) return 2'b11;
        return x.odd ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/mdec_region.sv
module mdec_region
    import mdec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              board_space
);
    always_comb begin
        region      = region_of(addr);
        board_space = in_board_space(addr);
    end
endmodule

// File: rtl/mdec_mem.sv
module mdec_mem
    import mdec_pkg::*;
(
    input  region_e    region,
    input  logic       mem_req,
    input  logic       blocked,
    input  xfer_t      xfer,
    output mem_sel_t   sel,
    output logic [1:0] lanes
);
    logic rom_ok;
    logic ram_hit;

    always_comb begin
        rom_ok  = mem_req && !blocked && !xfer.refresh;
        ram_hit = mem_req && !blocked && (xfer.refresh || region == RGN_RAM);

        sel.mon     = rom_ok && (region == RGN_MON);
        sel.asm_rom = rom_ok && (region == RGN_ASM);
        sel.ram     = ram_hit;

        if (sel.mon || sel.asm_rom) lanes = 2'b11;
        else if (sel.ram)           lanes = ram_lanes(xfer);
        else                        lanes = 2'b00;
    end
endmodule

// File: rtl/mdec_io.sv
module mdec_io #(
    parameter int IO_PORTS = 16,
    parameter int IDX_W    = 10
) (
    input  logic                io_req,
    input  logic [IDX_W-1:0]    port_idx,
    output logic [IO_PORTS-1:0] io_sel
);
    for (genvar k = 0; k < IO_PORTS; k++) begin : g_port
        assign io_sel[k] = io_req && (port_idx == IDX_W'(k));
    end
endmodule

// File: rtl/mdec_wait.sv
module mdec_wait (
    input  logic clk,
    input  logic rst,
    input  logic t2_end,
    input  logic wait_en,
    input  logic any_sel,
    output logic wait_req
);
    always_ff @(posedge clk) begin
        if (rst) wait_req <= 1'b0;
        else     wait_req <= t2_end && wait_en && any_sel;
    end
endmodule

// File: rtl/board_mem_decode.sv
module board_mem_decode
    import mdec_pkg::*;
#(
    parameter int IO_PORTS = 16,
    parameter int IO_MSB   = 11,
    parameter int IO_LSB   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [15:0]         addr,
    input  logic                mem_req,
    input  logic                io_req,
    input  logic                wr,
    input  logic                byte_op,
    input  logic                refresh,
    input  logic                t2_end,
    input  logic                wait_en,
    input  logic [1:0]          inh_mode,
    input  logic                inh_in_n,
    output logic                sel_mon,
    output logic                sel_asm,
    output logic                sel_ram,
    output logic [1:0]          lane_en,
    output logic                inh_out_n,
    output logic                inh_oe,
    output logic                wait_req,
    output logic [IO_PORTS-1:0] io_sel
);
    localparam int IDX_W = IO_MSB - IO_LSB + 1;

    region_e   region;
    logic      board_space;
    logic      blocked;
    inh_mode_e mode;
    mem_sel_t  sel;
    xfer_t     xfer;

    assign mode    = inh_mode_e'(inh_mode);
    assign blocked = (mode == INH_SAMPLE) && !inh_in_n;
    assign xfer    = '{wr: wr, byte_op: byte_op, odd: addr[0], refresh: refresh};

    mdec_region u_region (
        .addr        (addr),
        .region      (region),
        .board_space (board_space)
    );

    mdec_mem u_mem (
        .region  (region),
        .mem_req (mem_req),
        .blocked (blocked),
        .xfer    (xfer),
        .sel     (sel),
        .lanes   (lane_en)
    );

    mdec_io #(.IO_PORTS(IO_PORTS), .IDX_W(IDX_W)) u_io (
        .io_req   (io_req),
        .port_idx (addr[IO_MSB:IO_LSB]),
        .io_sel   (io_sel)
    );

    mdec_wait u_wait (
        .clk      (clk),
        .rst      (rst),
        .t2_end   (t2_end),
        .wait_en  (wait_en),
        .any_sel  (sel.mon || sel.asm_rom || sel.ram),
        .wait_req (wait_req)
    );

    assign sel_mon   = sel.mon;
    assign sel_asm   = sel.asm_rom;
    assign sel_ram   = sel.ram;
    assign inh_oe    = (mode == INH_DRIVE);
    assign inh_out_n = !((mode == INH_DRIVE) && mem_req && board_space);

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_mon, sel_asm, sel_ram}));

    // R5
    refresh_rom_off_chk: assert property (@(posedge clk) disable iff (rst)
        refresh |-> (!sel_mon && !sel_asm));

    // R7
    inhibit_block_chk: assert property (@(posedge clk) disable iff (rst)
        (inh_mode == 2'b10 && !inh_in_n) |-> (lane_en == 2'b00 && !sel_ram));

    // R3
    byte_write_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_ram && wr && byte_op && !refresh) |-> ($countones(lane_en) == 1));

    // R9
    wait_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wait_req) |-> ($past(t2_end) && $past(wait_en)));

    // R10
    io_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !io_req |-> (io_sel == '0));

    // R10
    io_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(io_sel));
endmodule

// File: tb/test_board_mem_decode.sv
module test_board_mem_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        mem_req = 0, io_req = 0, wr = 0, byte_op = 0, refresh = 0;
    logic        t2_end = 0, wait_en = 0, inh_in_n = 1;
    logic [1:0]  inh_mode = 2'b00;
    logic        sel_mon, sel_asm, sel_ram, inh_out_n, inh_oe, wait_req;
    logic [1:0]  lane_en;
    logic [15:0] io_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    board_mem_decode i_board_mem_decode (
        .clk(clk), .rst(rst), .addr(addr), .mem_req(mem_req), .io_req(io_req),
        .wr(wr), .byte_op(byte_op), .refresh(refresh), .t2_end(t2_end),
        .wait_en(wait_en), .inh_mode(inh_mode), .inh_in_n(inh_in_n),
        .sel_mon(sel_mon), .sel_asm(sel_asm), .sel_ram(sel_ram),
        .lane_en(lane_en), .inh_out_n(inh_out_n), .inh_oe(inh_oe),
        .wait_req(wait_req), .io_sel(io_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
        end
    endtask

    // expected model, written from the requirements
    function automatic logic [2:0] exp_sel();
        logic blk = (inh_mode == 2'b10) && !inh_in_n;
        logic rom = mem_req && !blk && !refresh;
        logic m   = rom && addr < 16'h1000;
        logic a   = rom && addr >= 16'h1000 && addr < 16'h3000;
        logic r   = mem_req && !blk && (refresh || (addr >= 16'h4000 && addr < 16'h6000));
        return {m, a, r};
    endfunction

    function automatic logic [1:0] exp_lanes(input logic [2:0] s);
        if (s[2] || s[1]) return 2'b11;
        if (s[0]) begin
            if (refresh || !wr || !byte_op) return 2'b11;
            return addr[0] ? 2'b10 : 2'b01;
        end
        return 2'b00;
    endfunction

    function automatic logic [15:0] exp_io();
        logic [15:0] v = '0;
        if (io_req && addr[11:2] < 10'd16) v[addr[5:2]] = 1'b1;
        return v;
    endfunction

    function automatic string sel_tag();
        if (inh_mode == 2'b10 && !inh_in_n) return "R7";
        if (refresh) return "R5";
        if (inh_mode != 2'b10 && !inh_in_n) return "R8";
        return "R1";
    endfunction

    function automatic string lane_tag(input logic [2:0] s);
        if (s[2] || s[1]) return "R4";
        if (s[0] && wr && byte_op && !refresh) return "R3";
        return "R2";
    endfunction

    // drive at a falling edge, check combinational outputs, then the registered wait
    task automatic step(input logic [15:0] a, input logic m, input logic io, input logic w,
                        input logic b, input logic rf, input logic t2, input logic we,
                        input logic [1:0] md, input logic ih);
        logic [2:0] s;
        logic       exp_w;
        addr = a; mem_req = m; io_req = io; wr = w; byte_op = b; refresh = rf;
        t2_end = t2; wait_en = we; inh_mode = md; inh_in_n = ih;
        #1;
        s = exp_sel();
        check(sel_tag(), {29'd0, sel_mon, sel_asm, sel_ram}, {29'd0, s});
        check(lane_tag(s), {30'd0, lane_en}, {30'd0, exp_lanes(s)});
        check((md == 2'b01) ? "R6" : "R8", {30'd0, inh_oe, inh_out_n},
              {30'd0, md == 2'b01, !((md == 2'b01) && m && a < 16'h6000)});
        check("R10", {16'd0, io_sel}, {16'd0, exp_io()});
        exp_w = t2 && we && (s != 3'b000);
        @(negedge clk);
        check("R9", {31'd0, wait_req}, {31'd0, exp_w});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R9 reset", {31'd0, wait_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 map boundaries, word reads
        step(16'h0000, 1,0,0,0,0,0,0,2'b00,1);
        step(16'h0FFF, 1,0,0,0,0,0,0,2'b00,1);
        step(16'h1000, 1,0,0,0,0,0,0,2'b00,1);
        step(16'h2FFF, 1,0,0,0,0,0,0,2'b00,1);
        step(16'h3000, 1,0,0,0,0,0,0,2'b00,1);
        step(16'h3FFF, 1,0,0,0,0,0,0,2'b00,1);
        step(16'h4000, 1,0,0,0,0,0,0,2'b00,1);
        step(16'h5FFF, 1,0,0,0,0,0,0,2'b00,1);
        step(16'h6000, 1,0,0,0,0,0,0,2'b00,1);
        step(16'hFFFF, 1,0,0,0,0,0,0,2'b00,1);
        step(16'h0800, 0,0,0,0,0,0,0,2'b00,1);
        // R2 RAM byte read, R3 byte writes even and odd, word write
        step(16'h4001, 1,0,0,1,0,0,0,2'b00,1);
        step(16'h4002, 1,0,1,1,0,0,0,2'b00,1);
        step(16'h4003, 1,0,1,1,0,0,0,2'b00,1);
        step(16'h4004, 1,0,1,0,0,0,0,2'b00,1);
        // R4 ROM byte write and byte read
        step(16'h0011, 1,0,1,1,0,0,0,2'b00,1);
        step(16'h2001, 1,0,0,1,0,0,0,2'b00,1);
        // R5 refresh at ROM and hole addresses
        step(16'h0100, 1,0,0,0,1,0,0,2'b00,1);
        step(16'h3100, 1,0,0,0,1,0,0,2'b00,1);
        // R6 drive mode inside and outside board space
        step(16'h3800, 1,0,0,0,0,0,0,2'b01,1);
        step(16'h6000, 1,0,0,0,0,0,0,2'b01,1);
        step(16'h5FFF, 0,0,0,0,0,0,0,2'b01,1);
        // R7 sample mode blocks, including refresh
        step(16'h4000, 1,0,0,0,0,1,1,2'b10,0);
        step(16'h0000, 1,0,0,0,1,0,0,2'b10,0);
        step(16'h0000, 1,0,0,0,0,0,0,2'b10,1);
        // R8 inhibit input ignored in both unused codes
        step(16'h1234, 1,0,0,0,0,0,0,2'b00,0);
        step(16'h4321, 1,0,0,0,0,0,0,2'b11,0);
        // R9 wait on/off, back-to-back, off-board
        step(16'h4000, 1,0,0,0,0,1,1,2'b00,1);
        step(16'h4000, 1,0,0,0,0,1,1,2'b00,1);
        step(16'h4000, 1,0,0,0,0,0,1,2'b00,1);
        step(16'h4000, 1,0,0,0,0,1,0,2'b00,1);
        step(16'h3000, 1,0,0,0,0,1,1,2'b00,1);
        // R10 aliases in upper nibble and low bits, mem_req independence, range limit
        step(16'hF00F, 0,1,0,0,0,0,0,2'b00,1);
        step(16'h000C, 1,1,0,0,0,0,0,2'b00,1);
        step(16'h0040, 0,1,0,0,0,0,0,2'b00,1);
        step(16'h003C, 0,0,0,0,0,0,0,2'b00,1);

        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a = 16'($urandom);
            if (($urandom % 4) == 0) a[15:12] = 4'($urandom % 7);
            step(a, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 6) == 0, 1'($urandom), 1'($urandom),
                 2'($urandom), ($urandom % 3) != 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule